// File: doc/BRIEF.md
# Jump-Through-Table Target Unit

This unit executes a bounded, PC-relative table jump. On a start pulse it takes the address of the jump instruction, a 64-bit index operand, an unsigned immediate upper bound and a two-bit entry-size code. It first checks the index against the range from zero to the bound. An index outside that range is replaced by the slot just past the bound, which holds the default case. The unit then works out where the selected table entry lives and reads it through the instruction-fetch port.

The table starts immediately after the four-byte instruction. Each entry is a signed displacement of 1, 2, 4 or 8 bytes, counted in 4-byte units. The unit sign-extends the returned entry, multiplies it by four and adds it to the table base to form the branch target. A response flagged as an execute-permission fault gives a fault pulse instead of a target.

The unit has three states. ST_IDLE moves to ST_WAIT when start is seen. ST_WAIT stays put until a read response arrives. From ST_WAIT a clean response moves the unit to ST_DONE, and a faulting response returns it to ST_IDLE. ST_DONE always returns to ST_IDLE after one cycle.

Top module: `jtt_unit`

## Requirements
- R1: While rst_n is low, and in the cycle after it is released, busy, rd_req, done and fault are all 0.
- R2: A start seen in ST_IDLE gives rd_req = 1 in the next cycle. For an index i with 0 <= i <= max_bound, rd_addr = inst_addr + 4 + i * entry_bytes.
- R3: An index above max_bound (compared as a signed 64-bit value) selects slot max_bound + 1. This includes an index equal to max_bound + 1 and very large positive values. An index equal to max_bound stays in range.
- R4: A negative index (bit 63 set) selects slot max_bound + 1.
- R5: size_sel 0, 1, 2 and 3 select entry_bytes 1, 2, 4 and 8. rd_size carries size_sel unchanged while rd_req is high.
- R6: The displacement is the low 8, 16, 32 or 64 bits of rd_data, according to the size, sign-extended to 64 bits. Bits of rd_data above the entry width have no effect on the target.
- R7: A response without fault, accepted in ST_WAIT, gives done = 1 for exactly one cycle in the next cycle. In that cycle target = inst_addr + 4 + displacement * 4, modulo 2^64.
- R8: A response with rd_fault = 1, accepted in ST_WAIT, gives fault = 1 for exactly one cycle in the next cycle, with done = 0 and busy = 0.
- R9: While waiting for a response, rd_req stays high and rd_addr and rd_size stay unchanged. A start pulse while busy is ignored.
- R10: rd_resp received outside ST_WAIT is ignored: the unit stays idle and produces neither done nor fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a table jump (accepted in ST_IDLE only) |
| inst_addr | input | 64 | Address of the jump instruction |
| index | input | 64 | Index operand, taken as signed |
| max_bound | input | 16 | Largest in-range index (unsigned immediate) |
| size_sel | input | 2 | Entry size code: 0=1B, 1=2B, 2=4B, 3=8B |
| busy | output | 1 | Unit is not in ST_IDLE |
| rd_req | output | 1 | Fetch-port read request, held until the response |
| rd_addr | output | 64 | Byte address of the table entry |
| rd_size | output | 2 | Size code of the read |
| rd_resp | input | 1 | Read response strobe |
| rd_data | input | 64 | Read data; the entry sits in the low bits |
| rd_fault | input | 1 | Execute-permission fault on the read |
| done | output | 1 | Target valid this cycle |
| target | output | 64 | Branch target |
| fault | output | 1 | The table read faulted |

## Verification
Two situations are hard to reach from the ports. One is a start pulse or a stray response that arrives while the unit is in the wrong state. The other is arithmetic at the edges of the 64-bit space. The stimulus pulses start with different operands during a long response delay, and pulses rd_resp while the unit is idle, so that any leak shows up in the per-cycle comparison against the reference model. Separate cases place the instruction near the top of the address space so that the target wraps. Others use negative and very large indices, and fill rd_data with high bits that contradict the sign of the entry.

// File: rtl/jtt_pkg.sv
package jtt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd2
    } jtt_state_e;

    localparam int SIZE_CODES = 4;
endpackage

// File: rtl/jtt_slot_sel.sv
module jtt_slot_sel #(
    parameter int AW    = 64,
    parameter int IMM_W = 16
) (
    input  logic [AW-1:0]    idx,
    input  logic [IMM_W-1:0] bound,
    output logic [AW-1:0]    slot
);
    localparam int PADW = AW - IMM_W;

    logic [AW-1:0] bound_ext;
    logic          out_of_range;

    assign bound_ext    = {{PADW{1'b0}}, bound};
    assign out_of_range = idx[AW-1] || (idx > bound_ext);
    assign slot         = out_of_range ? (bound_ext + 1'b1) : idx;
endmodule

// File: rtl/jtt_entry_addr.sv
module jtt_entry_addr #(
    parameter int AW         = 64,
    parameter int INST_BYTES = 4
) (
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] slot,
    input  logic [1:0]    size_code,
    output logic [AW-1:0] base,
    output logic [AW-1:0] entry
);
    assign base  = pc + AW'(INST_BYTES);
    assign entry = base + (slot << size_code);
endmodule

// File: rtl/jtt_disp_ext.sv
module jtt_disp_ext #(
    parameter int AW    = 64,
    parameter int DW    = 64,
    parameter int SCALE = 2
) (
    input  logic [DW-1:0] raw,
    input  logic [1:0]    size_code,
    input  logic [AW-1:0] base,
    output logic [AW-1:0] dest
);
    logic [AW-1:0] ext [jtt_pkg::SIZE_CODES];
    logic [AW-1:0] disp;

    for (genvar g = 0; g < jtt_pkg::SIZE_CODES; g++) begin : g_ext
        localparam int W = 8 << g;
        if (W < AW) begin : g_narrow
            assign ext[g] = {{(AW-W){raw[W-1]}}, raw[W-1:0]};
        end else begin : g_full
            assign ext[g] = raw[AW-1:0];
        end
    end

    assign disp = ext[size_code];
    assign dest = base + (disp << SCALE);
endmodule

// File: rtl/jtt_unit.sv
module jtt_unit #(
    parameter int AW    = 64,
    parameter int IMM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW-1:0]    inst_addr,
    input  logic [AW-1:0]    index,
    input  logic [IMM_W-1:0] max_bound,
    input  logic [1:0]       size_sel,
    output logic             busy,
    output logic             rd_req,
    output logic [AW-1:0]    rd_addr,
    output logic [1:0]       rd_size,
    input  logic             rd_resp,
    input  logic [63:0]      rd_data,
    input  logic             rd_fault,
    output logic             done,
    output logic [AW-1:0]    target,
    output logic             fault
);
    import jtt_pkg::*;

    jtt_state_e    st_q, st_d;
    logic [AW-1:0] slot_c, base_c, entry_c, dest_c;
    logic [AW-1:0] base_q, addr_q, target_q;
    logic [1:0]    size_q;
    logic          fault_q;
    logic          take_start, take_resp;

    jtt_slot_sel #(.AW(AW), .IMM_W(IMM_W)) i_slot (
        .idx   (index),
        .bound (max_bound),
        .slot  (slot_c)
    );

    jtt_entry_addr #(.AW(AW), .INST_BYTES(4)) i_addr (
        .pc        (inst_addr),
        .slot      (slot_c),
        .size_code (size_sel),
        .base      (base_c),
        .entry     (entry_c)
    );

    jtt_disp_ext #(.AW(AW), .DW(64), .SCALE(2)) i_ext (
        .raw       (rd_data),
        .size_code (size_q),
        .base      (base_q),
        .dest      (dest_c)
    );

    assign take_start = (st_q == ST_IDLE) && start;
    assign take_resp  = (st_q == ST_WAIT) && rd_resp;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (start) st_d = ST_WAIT;
            ST_WAIT: if (rd_resp) st_d = rd_fault ? ST_IDLE : ST_DONE;
            ST_DONE: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            addr_q   <= '0;
            size_q   <= '0;
            target_q <= '0;
            fault_q  <= 1'b0;
        end else begin
            fault_q <= take_resp && rd_fault;
            if (take_start) begin
                base_q <= base_c;
                addr_q <= entry_c;
                size_q <= size_sel;
            end
            if (take_resp && !rd_fault) target_q <= dest_c;
        end
    end

    assign busy    = (st_q != ST_IDLE);
    assign rd_req  = (st_q == ST_WAIT);
    assign done    = (st_q == ST_DONE);
    assign rd_addr = addr_q;
    assign rd_size = size_q;
    assign target  = target_q;
    assign fault   = fault_q;
endmodule

// File: rtl/jtt_unit_checker.sv
module jtt_unit_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       rd_req,
    input logic [63:0] rd_addr,
    input logic [1:0] rd_size,
    input logic       rd_resp,
    input logic       rd_fault,
    input logic       done,
    input logic       fault
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !rd_req && !done && !fault));

    assert_start_requests_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> rd_req);

    assert_request_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_resp) |=> (rd_req && $stable(rd_addr) && $stable(rd_size)));

    assert_clean_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_resp && !rd_fault) |=> (done && !fault));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_fault_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_resp && rd_fault) |=> (fault && !done && !busy));

    assert_stray_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> (!busy && !done && !fault));
endmodule

bind jtt_unit jtt_unit_checker i_jtt_unit_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .rd_size  (rd_size),
    .rd_resp  (rd_resp),
    .rd_fault (rd_fault),
    .done     (done),
    .fault    (fault)
);

// File: tb/test_jtt_unit.sv
module test_jtt_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] inst_addr = '0;
    logic [63:0] index = '0;
    logic [15:0] max_bound = '0;
    logic [1:0]  size_sel = '0;
    logic        busy, rd_req, done, fault;
    logic [63:0] rd_addr, target;
    logic [1:0]  rd_size;
    logic        rd_resp = 1'b0;
    logic [63:0] rd_data = '0;
    logic        rd_fault = 1'b0;

    int    checks = 0;
    int    failures = 0;
    int    cycles = 0;
    string cur_tag = "R1";

    // reference model state
    int          m_state = 0;
    logic [63:0] m_base = '0, m_addr = '0, m_target = '0;
    logic [1:0]  m_size = '0;
    logic        m_fault = 1'b0;

    jtt_unit i_jtt_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .inst_addr(inst_addr),
        .index(index), .max_bound(max_bound), .size_sel(size_sel),
        .busy(busy), .rd_req(rd_req), .rd_addr(rd_addr), .rd_size(rd_size),
        .rd_resp(rd_resp), .rd_data(rd_data), .rd_fault(rd_fault),
        .done(done), .target(target), .fault(fault)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        longint signed sidx;
        longint signed disp;
        longint unsigned slot;
        int w;
        cycles++;
        if (cycles > 20000) begin
            failures++;
            $display("FAIL watchdog expired: actual cycles=%0d expected done earlier", cycles);
            finish_run();
        end
        if (!rst_n) begin
            m_state = 0;
            m_fault = 0;
        end else begin
            case (m_state)
                0: begin
                    m_fault = 0;
                    if (start) begin
                        sidx = index;
                        if (sidx < 0 || sidx > longint'(max_bound)) slot = longint'(max_bound) + 1;
                        else slot = index;
                        m_base = inst_addr + 4;
                        m_addr = m_base + slot * (64'd1 << size_sel);
                        m_size = size_sel;
                        m_state = 1;
                    end
                end
                1: begin
                    if (rd_resp) begin
                        if (rd_fault) begin
                            m_fault = 1;
                            m_state = 0;
                        end else begin
                            w = 8 * (1 << m_size);
                            disp = longint'(rd_data << (64 - w)) >>> (64 - w);
                            m_target = m_base + 64'(disp * 4);
                            m_state = 2;
                        end
                    end
                end
                default: m_state = 0;
            endcase
        end
    end

    task automatic check(string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", cur_tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        check("busy", 64'(busy), 64'(m_state != 0));
        check("rd_req", 64'(rd_req), 64'(m_state == 1));
        check("done", 64'(done), 64'(m_state == 2));
        check("fault", 64'(fault), 64'(m_fault));
        if (m_state == 1) begin
            check("rd_addr", rd_addr, m_addr);
            check("rd_size", 64'(rd_size), 64'(m_size));
        end
        if (m_state == 2) check("target", target, m_target);
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic run_jump(string tag, logic [63:0] pc, logic [63:0] idx,
                            logic [15:0] mx, logic [1:0] sz, logic [63:0] data,
                            logic flt, int delay, logic poke);
        cur_tag = tag;
        inst_addr = pc; index = idx; max_bound = mx; size_sel = sz;
        start = 1'b1;
        step();
        start = 1'b0;
        for (int k = 0; k < delay; k++) begin
            if (poke && k == 0) begin
                start = 1'b1; index = 64'd2; size_sel = 2'd0; inst_addr = 64'h5000;
            end
            step();
            start = 1'b0;
        end
        rd_resp = 1'b1; rd_data = data; rd_fault = flt;
        step();
        rd_resp = 1'b0; rd_fault = 1'b0; rd_data = '0;
        repeat (3) step();
    endtask

    initial begin
        cur_tag = "R1";
        repeat (3) step();
        rst_n = 1'b1;
        step();
        step();
        // R2 in-range word entry
        run_jump("R2", 64'h1000, 64'd3, 16'd10, 2'd2, 64'h10, 1'b0, 1, 1'b0);
        run_jump("R2", 64'h2000, 64'd0, 16'd0, 2'd3, 64'h3, 1'b0, 0, 1'b0);
        // R5 all sizes
        run_jump("R5", 64'h3000, 64'd5, 16'd9, 2'd0, 64'h7F, 1'b0, 2, 1'b0);
        run_jump("R5", 64'h3000, 64'd5, 16'd9, 2'd1, 64'h1234, 1'b0, 1, 1'b0);
        run_jump("R5", 64'h3000, 64'd5, 16'd9, 2'd3, 64'h0000_0001_0000_0000, 1'b0, 1, 1'b0);
        // R3 above bound, at bound, huge
        run_jump("R3", 64'h4000, 64'd11, 16'd10, 2'd2, 64'h20, 1'b0, 1, 1'b0);
        run_jump("R3", 64'h4000, 64'd10, 16'd10, 2'd1, 64'h20, 1'b0, 1, 1'b0);
        run_jump("R3", 64'h4000, 64'h7FFF_FFFF_FFFF_FFFF, 16'hFFFF, 2'd3, 64'h8, 1'b0, 1, 1'b0);
        // R4 negative index
        run_jump("R4", 64'h4000, 64'hFFFF_FFFF_FFFF_FFFF, 16'd7, 2'd2, 64'h40, 1'b0, 1, 1'b0);
        run_jump("R4", 64'h4000, 64'h8000_0000_0000_0000, 16'd3, 2'd0, 64'h1, 1'b0, 1, 1'b0);
        // R6 sign extension with contrary high bits
        run_jump("R6", 64'h8000, 64'd1, 16'd4, 2'd0, 64'h0000_0000_0000_0080, 1'b0, 1, 1'b0);
        run_jump("R6", 64'h8000, 64'd1, 16'd4, 2'd1, 64'hFFFF_FFFF_FFFF_7FFF, 1'b0, 1, 1'b0);
        run_jump("R6", 64'h8000, 64'd1, 16'd4, 2'd2, 64'h1234_5678_8000_0000, 1'b0, 1, 1'b0);
        // R7 wrap at the top of the address space
        run_jump("R7", 64'hFFFF_FFFF_FFFF_FFF0, 64'd0, 16'd2, 2'd2, 64'h10, 1'b0, 0, 1'b0);
        run_jump("R7", 64'h0000_0000_0000_0010, 64'd0, 16'd2, 2'd3, 64'hFFFF_FFFF_FFFF_FFF0, 1'b0, 1, 1'b0);
        // R8 fault response
        run_jump("R8", 64'h6000, 64'd2, 16'd5, 2'd2, 64'h4, 1'b1, 2, 1'b0);
        run_jump("R8", 64'h6000, 64'd9, 16'd5, 2'd1, 64'h4, 1'b1, 0, 1'b0);
        // R9 long wait with start poked while busy
        run_jump("R9", 64'h7000, 64'd4, 16'd8, 2'd1, 64'hFFFE, 1'b0, 12, 1'b1);
        // R10 stray response while idle
        cur_tag = "R10";
        rd_resp = 1'b1; rd_data = 64'h55; rd_fault = 1'b0;
        step();
        rd_fault = 1'b1;
        step();
        rd_resp = 1'b0; rd_fault = 1'b0;
        repeat (3) step();
        run_jump("R10", 64'h9000, 64'd1, 16'd1, 2'd0, 64'hFF, 1'b0, 1, 1'b0);
        // R1 reset in the middle of a wait
        cur_tag = "R1";
        inst_addr = 64'hA000; index = 64'd1; max_bound = 16'd3; size_sel = 2'd2;
        start = 1'b1;
        step();
        start = 1'b0;
        step();
        rst_n = 1'b0;
        repeat (2) step();
        rst_n = 1'b1;
        repeat (3) step();
        finish_run();
    end
endmodule